// File: doc/BRIEF.md
# Multi-Channel Logic Trigger Matcher

This block watches a bus of logic input channels and tells the acquisition sequencer when a configured pattern appears. Every channel that takes part is tested either on its level or on a transition. One condition is set per channel: level mode tests for high or low, and edge mode tests for a falling or a rising transition. The trigger fires only when every participating channel meets its condition on the same sample.

Samples count only on cycles where the clock divider raises the sample strobe. The block keeps the previous counted sample so that it can detect transitions. An arm pulse starts a new search. On the first match the block emits a one-cycle trigger pulse and sets a sticky flag. The flag holds, and further matches are ignored, until the next arm pulse.

Top module: `trig_matcher`

## Requirements
- R1: While reset is asserted, and right after it, the trigger pulse and the triggered flag are 0 and the block is not armed.
- R2: Before the first arm pulse after reset, no sample can produce a trigger, even a matching one.
- R3: A participating channel whose mode bit is 1 (level) matches when its input equals its polarity bit: polarity 1 matches a high input, polarity 0 matches a low input.
- R4: A participating channel whose mode bit is 0 (edge) compares the current counted sample with the previous counted sample. Polarity 1 matches a 1-to-0 transition and polarity 0 matches a 0-to-1 transition.
- R5: The trigger fires only when all participating channels match on the same counted sample. The pulse appears on the cycle after that sample is presented.
- R6: A channel takes part only when its bit is 1 in both the active mask and the enabled mask. The input, mode and polarity of every other channel have no effect.
- R7: When no channel has its bit set in both masks, no trigger pulse is produced.
- R8: The first counted sample after an arm pulse cannot produce an edge match, because no earlier sample is valid.
- R9: The trigger pulse lasts exactly one cycle and fires at most once per arm. The triggered flag rises with the pulse and stays set until the next arm pulse, which clears it.
- R10: On cycles with the sample strobe low, nothing is evaluated and the stored previous sample keeps its value.
- R11: A sample presented in the same cycle as an arm pulse is discarded. It cannot match, and it does not become the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | One-cycle pulse: start a new trigger search |
| smp_en_i | input | 1 | Sample strobe from the clock divider |
| din_i | input | NCH | Logic input channels |
| act_mask_i | input | NCH | Active channels |
| en_mask_i | input | NCH | Channels enabled for the trigger |
| lvl_mask_i | input | NCH | 1 = level mode, 0 = edge mode |
| pol_mask_i | input | NCH | 1 = high or falling, 0 = low or rising |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky flag, set by the trigger and cleared by arm |

## Verification
The bench builds the block with its default width of 16 channels. Single-channel conditions are placed on bits 0 through 8, and all-ones patterns drive every bit up to 15, so both ends of the masks and the AND across distant channels are reached. With this width, a match can be made to depend on one channel that is excluded only through the active mask. It also exposes every input, mode and polarity combination of the match logic.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic {
        MK_EDGE  = 1'b0,
        MK_LEVEL = 1'b1
    } match_kind_e;

    typedef struct packed {
        logic armed;
        logic seen;
        logic pulse;
    } tm_ctrl_t;

    function automatic logic level_hit(input logic cur, input logic pol);
        return pol ? cur : ~cur;
    endfunction

    function automatic logic edge_hit(input logic prev, input logic cur,
                                      input logic pol);
        return pol ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/tm_sample_hist.sv
module tm_sample_hist #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_i,
    input  logic         smp_en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] prev_o,
    output logic         prev_vld_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         vld;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d.vld = 1'b0;
        end else if (smp_en_i) begin
            st_d.prev = din_i;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_o     = st_q.prev;
    assign prev_vld_o = st_q.vld;

    assert_hist_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en_i && !arm_i) |=> (prev_vld_o && prev_o == $past(din_i)));

    assert_arm_clears_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !prev_vld_o);

    assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en_i && !arm_i) |=> ($stable(prev_o) && $stable(prev_vld_o)));

endmodule

// File: rtl/tm_chan_match.sv
module tm_chan_match
    import tm_pkg::*;
(
    input  logic cur_i,
    input  logic prev_i,
    input  logic prev_vld_i,
    input  logic lvl_i,
    input  logic pol_i,
    input  logic part_i,
    output logic ok_o
);

    match_kind_e kind;
    logic        hit;

    always_comb begin
        kind = match_kind_e'(lvl_i);
        unique case (kind)
            MK_LEVEL: hit = level_hit(cur_i, pol_i);
            MK_EDGE:  hit = prev_vld_i & edge_hit(prev_i, cur_i, pol_i);
            default:  hit = 1'b0;
        endcase
        ok_o = hit | ~part_i;
    end

endmodule

// File: rtl/tm_trig_ctrl.sv
module tm_trig_ctrl
    import tm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic smp_en_i,
    input  logic any_part_i,
    input  logic all_ok_i,
    output logic pulse_o,
    output logic seen_o
);

    tm_ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        if (arm_i) begin
            ctl_d.armed = 1'b1;
            ctl_d.seen  = 1'b0;
        end else if (ctl_q.armed && !ctl_q.seen && smp_en_i &&
                     any_part_i && all_ok_i) begin
            ctl_d.pulse = 1'b1;
            ctl_d.seen  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pulse_o = ctl_q.pulse;
    assign seen_o  = ctl_q.seen;

    assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_o && !arm_i) |=> seen_o);

    assert_flag_rises_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_o) |-> pulse_o);

    assert_arm_discards_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!seen_o && !pulse_o));

    assert_pulse_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(smp_en_i));

endmodule

// File: rtl/trig_matcher.sv
module trig_matcher #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm_i,
    input  logic           smp_en_i,
    input  logic [NCH-1:0] din_i,
    input  logic [NCH-1:0] act_mask_i,
    input  logic [NCH-1:0] en_mask_i,
    input  logic [NCH-1:0] lvl_mask_i,
    input  logic [NCH-1:0] pol_mask_i,
    output logic           trig_pulse_o,
    output logic           triggered_o
);

    localparam int CW = NCH;

    logic [CW-1:0] prev_q;
    logic          prev_vld_q;
    logic [CW-1:0] part;
    logic [CW-1:0] ok_vec;
    logic          any_part;
    logic          all_ok;

    tm_sample_hist #(.W(CW)) hist_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .smp_en_i   (smp_en_i),
        .din_i      (din_i),
        .prev_o     (prev_q),
        .prev_vld_o (prev_vld_q)
    );

    assign part = en_mask_i & act_mask_i;

    for (genvar c = 0; c < CW; c++) begin : g_chan
        tm_chan_match match_i (
            .cur_i      (din_i[c]),
            .prev_i     (prev_q[c]),
            .prev_vld_i (prev_vld_q),
            .lvl_i      (lvl_mask_i[c]),
            .pol_i      (pol_mask_i[c]),
            .part_i     (part[c]),
            .ok_o       (ok_vec[c])
        );
    end

    assign any_part = |part;
    assign all_ok   = &ok_vec;

    tm_trig_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .smp_en_i   (smp_en_i),
        .any_part_i (any_part),
        .all_ok_i   (all_ok),
        .pulse_o    (trig_pulse_o),
        .seen_o     (triggered_o)
    );

    assert_empty_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_mask_i & act_mask_i) == '0) |=> !trig_pulse_o);

    assert_outputs_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({trig_pulse_o, triggered_o}));

endmodule

// File: tb/trig_matcher_tb_top.sv
module trig_matcher_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 16;
    localparam int NV         = 37;
    localparam int WDOG_LIMIT = 20000;

    typedef struct packed {
        logic        arm;
        logic        se;
        logic [15:0] din;
        logic [15:0] act;
        logic [15:0] en;
        logic [15:0] lvl;
        logic [15:0] pol;
        logic        ep;
        logic        es;
        logic [7:0]  rq;
    } vec_t;

    // arm se din act en lvl pol | exp pulse, exp flag, requirement
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,16'h0001,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b0,8'd2},  // R2 unarmed
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b0,8'd3},  // R3 want high
        '{1'b0,1'b1,16'h0001,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b1,1'b1,8'd3},  // R3 hit
        '{1'b0,1'b1,16'h0001,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b1,8'd9},  // R9 once
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0002,16'h0002,16'h0000,1'b0,1'b0,8'd9},  // R9 rearm
        '{1'b0,1'b1,16'h0002,16'hFFFF,16'h0002,16'h0002,16'h0000,1'b0,1'b0,8'd3},  // R3 want low
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0002,16'h0002,16'h0000,1'b1,1'b1,8'd3},
        '{1'b1,1'b1,16'h0000,16'hFFFF,16'h0002,16'h0002,16'h0000,1'b0,1'b0,8'd11}, // R11
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0002,16'h0002,16'h0000,1'b1,1'b1,8'd11},
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0004,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b0,1'b0,8'd8},  // R8
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b0,1'b0,8'd4},  // R4 fall, want rise
        '{1'b0,1'b0,16'h0004,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b0,1'b0,8'd10}, // R10
        '{1'b0,1'b0,16'h0004,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b0,1'b0,8'd10},
        '{1'b0,1'b1,16'h0004,16'hFFFF,16'h0004,16'h0000,16'h0000,1'b1,1'b1,8'd10}, // R10 prev kept 0
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0008,16'h0000,16'h0008,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0008,16'h0000,16'h0008,1'b0,1'b0,8'd8},
        '{1'b0,1'b1,16'h0008,16'hFFFF,16'h0008,16'h0000,16'h0008,1'b0,1'b0,8'd4},  // R4 rise, want fall
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0008,16'h0000,16'h0008,1'b1,1'b1,8'd4},
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0011,16'h0011,16'h0011,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0001,16'hFFFF,16'h0011,16'h0011,16'h0011,1'b0,1'b0,8'd5},  // R5 partial
        '{1'b0,1'b1,16'h0010,16'hFFFF,16'h0011,16'h0011,16'h0011,1'b0,1'b0,8'd5},
        '{1'b0,1'b1,16'h0011,16'hFFFF,16'h0011,16'h0011,16'h0011,1'b1,1'b1,8'd5},
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0101,16'h0001,16'h0100,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0100,16'hFFFF,16'h0101,16'h0001,16'h0100,1'b0,1'b0,8'd5},
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0101,16'h0001,16'h0100,1'b1,1'b1,8'd5},  // R5 mixed
        '{1'b1,1'b0,16'h0000,16'hFFFE,16'h0003,16'h0003,16'h0003,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0002,16'hFFFE,16'h0003,16'h0003,16'h0003,1'b1,1'b1,8'd6},  // R6 inactive ch0
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0000,16'hFFFF,16'hFFFF,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'h0000,16'hFFFF,16'h0000,16'hFFFF,16'hFFFF,1'b0,1'b0,8'd7},  // R7
        '{1'b0,1'b1,16'hFFFF,16'hFFFF,16'h0000,16'hFFFF,16'hFFFF,1'b0,1'b0,8'd7},
        '{1'b1,1'b0,16'h0000,16'h0000,16'hFFFF,16'hFFFF,16'hFFFF,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'hFFFF,16'h0000,16'hFFFF,16'hFFFF,16'hFFFF,1'b0,1'b0,8'd7},  // R7 act zero
        '{1'b1,1'b0,16'h0000,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b0,8'd9},
        '{1'b0,1'b1,16'hFFFE,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b0,1'b0,8'd6},  // R6 others ignored
        '{1'b0,1'b1,16'h5A5B,16'hFFFF,16'h0001,16'h0001,16'h0001,1'b1,1'b1,8'd6}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm_i = 1'b0;
    logic           smp_en_i = 1'b0;
    logic [NCH-1:0] din_i = '0;
    logic [NCH-1:0] act_mask_i = '0;
    logic [NCH-1:0] en_mask_i = '0;
    logic [NCH-1:0] lvl_mask_i = '0;
    logic [NCH-1:0] pol_mask_i = '0;
    logic           trig_pulse_o;
    logic           triggered_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_matcher #(.NCH(NCH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm_i),
        .smp_en_i     (smp_en_i),
        .din_i        (din_i),
        .act_mask_i   (act_mask_i),
        .en_mask_i    (en_mask_i),
        .lvl_mask_i   (lvl_mask_i),
        .pol_mask_i   (pol_mask_i),
        .trig_pulse_o (trig_pulse_o),
        .triggered_o  (triggered_o)
    );

    task automatic chk(input logic act, input logic exp, input int rq,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%b expected=%b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        arm_i      = v.arm;
        smp_en_i   = v.se;
        din_i      = v.din;
        act_mask_i = v.act;
        en_mask_i  = v.en;
        lvl_mask_i = v.lvl;
        pol_mask_i = v.pol;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(trig_pulse_o, 1'b0, 1, "pulse in reset");
        chk(triggered_o, 1'b0, 1, "flag in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(trig_pulse_o, 1'b0, 1, "pulse after reset");
        chk(triggered_o, 1'b0, 1, "flag after reset");

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            chk(trig_pulse_o, TBL[i].ep, int'(TBL[i].rq), $sformatf("row %0d pulse", i));
            chk(triggered_o, TBL[i].es, int'(TBL[i].rq), $sformatf("row %0d flag", i));
        end

        // R1: reset mid-run clears the flag and the armed state
        arm_i = 1'b0; smp_en_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(triggered_o, 1'b0, 1, "flag cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: matching sample after reset without arm
        smp_en_i = 1'b1; din_i = 16'h0001;
        en_mask_i = 16'h0001; act_mask_i = 16'hFFFF;
        lvl_mask_i = 16'h0001; pol_mask_i = 16'h0001;
        @(negedge clk);
        chk(trig_pulse_o, 1'b0, 2, "no pulse before arm");
        chk(triggered_o, 1'b0, 2, "no flag before arm");
        smp_en_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int n = 0; n < WDOG_LIMIT; n++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule